// File: doc/BRIEF.md
# Card data-path FIFO engine

This block moves transfer data for a memory-card host controller. Software programs a byte length and then writes the data-control register with the enable bit set. From that point a down-counting byte counter governs a transfer between a word FIFO and a byte-wide card port. In card-to-host mode, bytes from the card are packed into 32-bit words and queued for the bus to read. In host-to-card mode, words that the bus writes are unpacked and presented to the card one byte at a time.

The FIFO is reached through a window of sixteen word addresses, all of which alias the same queue. The remaining-word register is computed from the byte counter; it is not a counter of its own. A hold-off mode can be selected. In that mode, every successful FIFO read stalls the card side until software reads the status or the remaining-word register. The engine raises a block-end flag when the counter runs out, and it clears its own enable bit once the counter is zero and the FIFO has drained.

Top module: `card_dpath_engine`

## Requirements
- R1: After reset, data-control, the byte counter (0x30), status (0x34) and the remaining-word register (0x48) all read 0, crd_rx_rdy_o and crd_tx_vld_o are low, and the FIFO is empty.
- R2: A write to data-control (0x2C) keeps only bits [7:0]. Bit 0 is enable and bit 1 selects card-to-host (1) or host-to-card (0). A write with bit 0 set loads the byte counter from the length register (0x28) and clears the block-end flag.
- R3: Every word address from 0x80 to 0xBC reaches the same FIFO, for reads and for writes.
- R4: A FIFO-window read while the FIFO is empty returns 0 and changes no state. In particular it does not set the hold flag.
- R5: A FIFO-window write is dropped when the byte counter is zero or the FIFO is full. Otherwise the word is pushed.
- R6: 0x48 reads (count+3)>>2, where count is the byte counter. The counter only loads on an enabling write or drops by one per byte moved.
- R7: In card-to-host mode, a byte is taken (crd_rx_rdy_o high) only when crd_rx_vld_i is high, the counter is non-zero, the FIFO is not full and no hold is pending. Bytes are packed little-endian, with the first byte in bits [7:0]. When the counter reaches zero, a partial last word is pushed with its unused upper bytes set to zero.
- R8: In host-to-card mode, crd_tx_vld_o is high whenever the FIFO holds an unsent byte and the counter is non-zero. Bytes leave each word starting with bits [7:0]. Exactly count bytes are sent, and the rest of the last word is discarded.
- R9: Status bit 0 (block end) is set when a byte transfer brings the counter to zero. It is not set by an enabling write with length 0.
- R10: The enable bit clears itself one cycle after the counter is zero and the FIFO is empty. The other data-control bits keep their values.
- R11: With hold_mode_i high, a successful FIFO read sets a hold that blocks all card transfers. A read of 0x34 or 0x48 releases the hold.
- R12: The FIFO never overflows or underflows. Card-to-host transfer stalls while the FIFO is full, and host-to-card transfer stalls while it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; read side effects take place at the clock edge |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as the strobe |
| hold_mode_i | input | 1 | Selects hold-off after FIFO reads |
| crd_rx_vld_i | input | 1 | Card has a byte ready (card-to-host) |
| crd_rx_data_i | input | 8 | Byte from the card |
| crd_rx_rdy_o | output | 1 | Byte taken this cycle |
| crd_tx_vld_o | output | 1 | Byte offered to the card (host-to-card) |
| crd_tx_data_o | output | 8 | Byte to the card |
| crd_tx_rdy_i | input | 1 | Card accepts the offered byte |

## Verification
The bench uses the default parameters: a FIFO depth of 16 words and a 16-bit byte counter. Transfers run up to 80 bytes, which is more than the FIFO holds. Together with bus reads held back at the start, this makes the full stall of the card-to-host path reachable. In host-to-card mode, a directed test fills the FIFO and then makes a seventeenth write that must be dropped. Lengths that are not a multiple of four exercise the partial last word in both directions.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_DLEN  = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_DCTRL = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_DCNT  = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_FCNT  = 12'h048;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_RX_BIT = 1;

  // 0x80..0xBF: sixteen aliased FIFO words
  function automatic logic is_fifo_win(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:6] == 6'h02;
  endfunction
endpackage

// File: rtl/cdp_word_fifo.sv
module cdp_word_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  assign full_o  = cnt_q == (PW+1)'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  a_r12_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/cdp_byte_lane.sv
module cdp_byte_lane #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             en_i,
  input  logic             dir_rx_i,
  input  logic             hold_i,
  input  logic             fifo_full_i,
  input  logic             fifo_empty_i,
  input  logic [31:0]      fifo_head_i,
  input  logic             crd_rx_vld_i,
  input  logic [7:0]       crd_rx_data_i,
  output logic             crd_rx_rdy_o,
  output logic             crd_tx_vld_o,
  output logic [7:0]       crd_tx_data_o,
  input  logic             crd_tx_rdy_i,
  output logic             push_o,
  output logic [31:0]      push_word_o,
  output logic             pop_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       lane_q;
  logic [31:0]      pack_q;
  logic             can_move, rx_fire, tx_fire, last, word_end;

  assign can_move = en_i && (cnt_q != '0) && !hold_i;
  assign rx_fire  = can_move && dir_rx_i && crd_rx_vld_i && !fifo_full_i;
  assign crd_tx_vld_o = can_move && !dir_rx_i && !fifo_empty_i;
  assign tx_fire  = crd_tx_vld_o && crd_tx_rdy_i;
  assign last     = cnt_q == CNT_W'(1);
  assign word_end = (lane_q == 2'd3) || last;

  assign crd_rx_rdy_o  = rx_fire;
  assign crd_tx_data_o = fifo_head_i[{lane_q, 3'b000} +: 8];
  assign push_o = rx_fire && word_end;
  assign pop_o  = tx_fire && word_end;
  assign done_o = (rx_fire || tx_fire) && last;
  assign cnt_o  = cnt_q;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign push_word_o[i*8 +: 8] = (lane_q == 2'(i)) ? crd_rx_data_i : pack_q[i*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lane_q <= '0;
      pack_q <= '0;
    end else if (start_i) begin
      cnt_q  <= len_i;
      lane_q <= '0;
      pack_q <= '0;
    end else if (rx_fire || tx_fire) begin
      cnt_q  <= cnt_q - 1'b1;
      lane_q <= word_end ? 2'd0 : lane_q + 1'b1;
      if (rx_fire) pack_q <= word_end ? 32'h0 : push_word_o;
    end
  end

  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  a_r11_hold_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !(crd_rx_rdy_o || crd_tx_vld_o));
  a_r7_rx_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crd_rx_rdy_o |-> (crd_rx_vld_i && dir_rx_i && !fifo_full_i));
endmodule

// File: rtl/card_dpath_engine.sv
module card_dpath_engine
  import cdp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              hold_mode_i,
  input  logic              crd_rx_vld_i,
  input  logic [7:0]        crd_rx_data_i,
  output logic              crd_rx_rdy_o,
  output logic              crd_tx_vld_o,
  output logic [7:0]        crd_tx_data_o,
  input  logic              crd_tx_rdy_i
);
  logic [CNT_W-1:0] dlen_q, cnt;
  logic [7:0]       ctrl_q;
  logic             blk_end_q, hold_q;
  logic             win, ctrl_wr, start, hold_clr;
  logic             eng_push, eng_pop, bus_push, bus_pop, done;
  logic             f_full, f_empty;
  logic [31:0]      eng_word, f_head;
  logic [CNT_W:0]   fc_sum;

  assign win      = is_fifo_win(reg_addr_i);
  assign ctrl_wr  = reg_wr_i && reg_addr_i == OFF_DCTRL;
  assign start    = ctrl_wr && reg_wdata_i[CTRL_EN_BIT];
  assign hold_clr = reg_rd_i && (reg_addr_i == OFF_STAT || reg_addr_i == OFF_FCNT);
  assign bus_pop  = reg_rd_i && win && !f_empty;
  // pushes gated by remaining count; engine push wins a collision
  assign bus_push = reg_wr_i && win && (cnt != '0) && !f_full && !eng_push;
  assign fc_sum   = {1'b0, cnt} + (CNT_W+1)'(3);

  cdp_byte_lane #(.CNT_W(CNT_W)) u_lane (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .len_i        (dlen_q),
    .en_i         (ctrl_q[CTRL_EN_BIT]),
    .dir_rx_i     (ctrl_q[CTRL_RX_BIT]),
    .hold_i       (hold_q),
    .fifo_full_i  (f_full),
    .fifo_empty_i (f_empty),
    .fifo_head_i  (f_head),
    .crd_rx_vld_i (crd_rx_vld_i),
    .crd_rx_data_i(crd_rx_data_i),
    .crd_rx_rdy_o (crd_rx_rdy_o),
    .crd_tx_vld_o (crd_tx_vld_o),
    .crd_tx_data_o(crd_tx_data_o),
    .crd_tx_rdy_i (crd_tx_rdy_i),
    .push_o       (eng_push),
    .push_word_o  (eng_word),
    .pop_o        (eng_pop),
    .done_o       (done),
    .cnt_o        (cnt)
  );

  cdp_word_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (eng_push || bus_push),
    .wdata_i(eng_push ? eng_word : reg_wdata_i),
    .pop_i  (eng_pop || bus_pop),
    .head_o (f_head),
    .full_o (f_full),
    .empty_o(f_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlen_q    <= '0;
      ctrl_q    <= '0;
      blk_end_q <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == OFF_DLEN) dlen_q <= reg_wdata_i[CNT_W-1:0];

      if (ctrl_wr) ctrl_q <= reg_wdata_i[7:0];
      else if (ctrl_q[CTRL_EN_BIT] && cnt == '0 && f_empty) ctrl_q[CTRL_EN_BIT] <= 1'b0;

      if (start)     blk_end_q <= 1'b0;
      else if (done) blk_end_q <= 1'b1;

      if (hold_clr)                    hold_q <= 1'b0;
      else if (bus_pop && hold_mode_i) hold_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (win) reg_rdata_o = f_empty ? 32'h0 : f_head;
    else begin
      case (reg_addr_i)
        OFF_DLEN:  reg_rdata_o = 32'(dlen_q);
        OFF_DCTRL: reg_rdata_o = {24'h0, ctrl_q};
        OFF_DCNT:  reg_rdata_o = 32'(cnt);
        OFF_STAT:  reg_rdata_o = {31'h0, blk_end_q};
        OFF_FCNT:  reg_rdata_o = 32'(fc_sum >> 2);
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  a_r10_idle_when_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl_q[CTRL_EN_BIT]) && !$past(ctrl_wr)) |-> ($past(cnt) == '0 && $past(f_empty)));
  a_r9_blkend_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_end_q) |-> cnt == '0);
  a_r5_no_push_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && win && cnt == '0) |=> $stable(f_empty));
  a_r4_empty_read_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && win && f_empty && !hold_q) |=> !hold_q);
endmodule

// File: tb/card_dpath_engine_tb.sv
module card_dpath_engine_tb;
  import cdp_pkg::*;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0, hold_mode = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rx_vld = 0, rx_rdy, tx_vld, tx_rdy = 0;
  logic [7:0]  rx_data = '0, tx_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] src [0:127];

  always #4 clk = ~clk;

  card_dpath_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .hold_mode_i(hold_mode),
    .crd_rx_vld_i(rx_vld), .crd_rx_data_i(rx_data), .crd_rx_rdy_o(rx_rdy),
    .crd_tx_vld_o(tx_vld), .crd_tx_data_o(tx_data), .crd_tx_rdy_i(tx_rdy)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] wd,
                      input bit rv, input logic [7:0] rdt, input bit tr,
                      output logic [31:0] rdo, output bit rxr, output bit txv, output logic [7:0] txd);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    rx_vld = rv; rx_data = rdt; tx_rdy = tr;
    #2;
    rdo = reg_rdata; rxr = rx_rdy; txv = tx_vld; txd = tx_data;
  endtask

  task automatic reg_wr_t(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; bit x, y; logic [7:0] z;
    step(1, 0, a, d, 0, 0, 0, r, x, y, z);
  endtask

  task automatic reg_rd_t(input logic [11:0] a, output logic [31:0] d);
    bit x, y; logic [7:0] z;
    step(0, 1, a, 0, 0, 0, 0, d, x, y, z);
  endtask

  task automatic idle(input int n);
    logic [31:0] r; bit x, y; logic [7:0] z;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, r, x, y, z);
  endtask

  function automatic logic [31:0] word_rx(input int k, input int len);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++) if (4*k + b < len) w[b*8 +: 8] = src[4*k + b];
    return w;
  endfunction

  function automatic logic [31:0] word_tx(input int k);
    return {src[4*k+3], src[4*k+2], src[4*k+1], src[4*k]};
  endfunction

  function automatic logic [11:0] win_addr();
    return 12'h080 | 12'(($urandom % 16) << 2);
  endfunction

  task automatic fill_src();
    for (int i = 0; i < 128; i++) src[i] = 8'($urandom);
  endtask

  task automatic rx_xfer(input int len, input bit hm, input int rd_pct, input int vld_pct, input int quiet);
    int idx = 0, nrd = 0, nw, n = 0;
    bit hexp = 0;
    logic [31:0] r;
    fill_src();
    hold_mode = hm;
    nw = (len + 3) / 4;
    reg_wr_t(OFF_DLEN, 32'(len));
    reg_wr_t(OFF_DCTRL, 32'h3);
    while ((idx < len || nrd < nw) && n < 20000) begin
      int comp, avail, rr, op;
      bit vld, rxr, txv, rexp;
      logic [7:0] txd;
      logic [11:0] a;
      comp  = (idx == len) ? nw : idx / 4;
      avail = comp - nrd;
      vld = ($urandom % 100) < vld_pct;
      rr = $urandom % 100;
      op = 0;
      if (n >= quiet) begin
        if (rr < rd_pct && avail > 0) op = 1;
        else if (rr < rd_pct + 12) op = 2;
        else if (rr < rd_pct + 17) op = 3;
        else if (rr < rd_pct + 20 && avail == 0) op = 4;
      end
      a = (op == 2) ? OFF_STAT : (op == 3) ? OFF_FCNT : win_addr();
      step(0, op != 0, a, 0, vld, src[idx], 0, r, rxr, txv, txd);
      rexp = vld && idx < len && !hexp && avail < DEPTH;
      chk(rxr == rexp, avail >= DEPTH ? "R12 rx stall on full" : hexp ? "R11 hold" : "R7 rx accept",
          32'(rxr), 32'(rexp));
      case (op)
        1: begin
          chk(r == word_rx(nrd, len), "R7 rx packing (R3 window)", r, word_rx(nrd, len));
          nrd++;
          if (hm) hexp = 1;
        end
        2: begin
          chk(r == 32'(idx == len && len > 0), "R9 block end", r, 32'(idx == len && len > 0));
          hexp = 0;
        end
        3: begin
          chk(r == 32'((len - idx + 3) >> 2), "R6 word count", r, 32'((len - idx + 3) >> 2));
          hexp = 0;
        end
        4: chk(r == 0, "R4 empty read", r, 0);
        default: ;
      endcase
      if (rxr && vld) idx++;
      n++;
    end
    idle(3);
    reg_rd_t(OFF_DCTRL, r); chk(r == 32'h2, "R10 rx enable cleared", r, 32'h2);
    reg_rd_t(OFF_STAT, r);  chk(r == 32'(len > 0), "R9 rx block end", r, 32'(len > 0));
    reg_rd_t(OFF_DCNT, r);  chk(r == 0, "R6 count zero", r, 0);
    reg_rd_t(win_addr(), r); chk(r == 0, "R4 drained read", r, 0);
    hold_mode = 0;
  endtask

  task automatic tx_xfer(input int len, input int wr_pct, input int rdy_pct);
    int idx = 0, nwr = 0, nw, n = 0;
    logic [31:0] r;
    fill_src();
    nw = (len + 3) / 4;
    reg_wr_t(OFF_DLEN, 32'(len));
    reg_wr_t(OFF_DCTRL, 32'h1);
    while (idx < len && n < 20000) begin
      int occ, lim;
      bit dw, tr, rxr, txv, vexp;
      logic [7:0] txd;
      occ = nwr - idx / 4;
      dw = nwr < nw && occ < DEPTH && ($urandom % 100) < wr_pct;
      tr = ($urandom % 100) < rdy_pct;
      step(dw, 0, win_addr(), word_tx(nwr), 0, 0, tr, r, rxr, txv, txd);
      lim = (4 * nwr < len) ? 4 * nwr : len;
      vexp = lim > idx;
      chk(txv == vexp, occ == 0 ? "R12 tx stall on empty" : "R8 tx valid", 32'(txv), 32'(vexp));
      if (txv && tr) begin
        chk(txd == src[idx], "R8 tx byte order", 32'(txd), 32'(src[idx]));
        idx++;
      end
      if (dw) nwr++;
      n++;
    end
    idle(3);
    reg_rd_t(OFF_DCTRL, r); chk(r == 0, "R10 tx enable cleared", r, 0);
    reg_rd_t(OFF_STAT, r);  chk(r == 32'(len > 0), "R9 tx block end", r, 32'(len > 0));
    reg_rd_t(OFF_FCNT, r);  chk(r == 0, "R6 word count zero", r, 0);
    reg_wr_t(win_addr(), 32'hCAFE_F00D);
    reg_rd_t(win_addr(), r); chk(r == 0, "R5 write dropped at zero count", r, 0);
  endtask

  initial begin
    logic [31:0] r;
    bit x, y;
    logic [7:0] z;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(rx_rdy == 0 && tx_vld == 0, "R1 card idle", 32'({rx_rdy, tx_vld}), 0);
    reg_rd_t(OFF_DCTRL, r); chk(r == 0, "R1 ctrl", r, 0);
    reg_rd_t(OFF_DCNT, r);  chk(r == 0, "R1 count", r, 0);
    reg_rd_t(OFF_STAT, r);  chk(r == 0, "R1 status", r, 0);
    reg_rd_t(OFF_FCNT, r);  chk(r == 0, "R1 word count", r, 0);
    reg_rd_t(12'h0A4, r);   chk(r == 0, "R1 fifo empty", r, 0);

    // R2: only low byte kept
    reg_wr_t(OFF_DCTRL, 32'hDEAD_BE5C);
    reg_rd_t(OFF_DCTRL, r); chk(r == 32'h5C, "R2 ctrl low byte", r, 32'h5C);
    reg_wr_t(OFF_DCTRL, 32'h0);

    // R9/R10: zero length start
    reg_wr_t(OFF_DLEN, 0);
    reg_wr_t(OFF_DCTRL, 32'h1);
    idle(2);
    reg_rd_t(OFF_DCTRL, r); chk(r == 0, "R10 zero length idles", r, 0);
    reg_rd_t(OFF_STAT, r);  chk(r == 0, "R9 no block end for zero length", r, 0);

    // R3: aliasing, first and last window word
    fill_src();
    reg_wr_t(OFF_DLEN, 8);
    reg_wr_t(OFF_DCTRL, 32'h3);
    reg_rd_t(OFF_DCNT, r); chk(r == 8, "R2 count loaded", r, 8);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, src[i], 0, r, x, y, z);
    idle(1);
    reg_rd_t(12'h0BC, r); chk(r == word_rx(0, 8), "R3 alias 0xBC", r, word_rx(0, 8));
    reg_rd_t(12'h080, r); chk(r == word_rx(1, 8), "R3 alias 0x80", r, word_rx(1, 8));

    // R5/R12: fill FIFO in host-to-card mode, 17th write dropped
    reg_wr_t(OFF_DLEN, 80);
    reg_wr_t(OFF_DCTRL, 32'h1);
    for (int k = 0; k < 17; k++) reg_wr_t(win_addr(), 32'h0101_0101 * 32'(k + 1));
    reg_rd_t(OFF_FCNT, r); chk(r == 20, "R6 word count 80 bytes", r, 20);
    for (int i = 0; i < 64; i++) begin
      step(0, 0, 0, 0, 0, 0, 1, r, x, y, z);
      chk(y && z == 8'(i / 4 + 1), "R8 tx drain", 32'(z), 32'(i / 4 + 1));
    end
    step(0, 0, 0, 0, 0, 0, 1, r, x, y, z);
    chk(y == 0, "R5 write dropped when full", 32'(y), 0);
    for (int k = 0; k < 4; k++) reg_wr_t(win_addr(), 32'hA0A0_A0A0 + 32'(k));
    for (int i = 0; i < 16; i++) begin
      step(0, 0, 0, 0, 0, 0, 1, r, x, y, z);
      chk(y && z == 8'(8'hA0 + ((i % 4 == 0) ? 8'(i / 4) : 8'h0)), "R8 tx refill", 32'(z),
          32'(8'hA0 + ((i % 4 == 0) ? 8'(i / 4) : 8'h0)));
    end
    idle(3);
    reg_rd_t(OFF_DCTRL, r); chk(r == 0, "R10 tx finished", r, 0);

    // R12: long card-to-host transfer with reads held back until full
    rx_xfer(80, 0, 40, 95, 100);
    rx_xfer(37, 1, 40, 70, 0);

    for (int t = 0; t < 16; t++) begin
      int len = $urandom % 41;
      if (t % 2 == 0) rx_xfer(len, 1'($urandom % 2), 30 + $urandom % 50, 30 + $urandom % 70, 0);
      else            tx_xfer(len, 30 + $urandom % 70, 30 + $urandom % 70);
    end

    summary();
    $finish;
  end
endmodule